// File: doc/BRIEF.md
# Sideband CPUID / Machine-Check Read Sequencer

This block runs one remote read against a processor's sideband register space. The remote read is either a CPUID function query or a machine-check register fetch. The caller gives a 64-bit request word and a kind bit. The sequencer then drives a byte-wide register-access port through a fixed series of accesses. It caches the remote revision, selects the thread bank and writes the packed request message. It then polls for the hardware-completion flag, reads the response back and acknowledges the flag. At the end it returns a 64-bit result together with an error code.

The register port carries one access at a time. An access is offered by holding `rp_req` together with its address, direction and write data. It completes in the cycle where `rp_ack` is high, and `rp_rdata` and `rp_err` are taken in that same cycle. The poll interval and the poll timeout are given in clock cycles.

Top module: `sb_cpuid_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rp_req`, `result`, `err_code` and `fw_code` are all zero.
- R2: The revision register (`REV_ADDR`) is read once, before the message traffic of the first request. Its value is cached, and later requests do not read it again.
- R3: If the cached revision is 0x10, every request ends with err_code 1 (not supported). After the revision read, no further register access is made.
- R4: Before every message, bits 47:32 of the request word are taken as the thread. One write goes to `BANK_ADDR`: 1 if the thread is above 127, 0 otherwise. The thread byte in the message is ((thread mod 128) << 1), truncated to 8 bits.
- R5: For kind 0 (CPUID), 9 bytes are written to addresses 0x73 to 0x7B in this order: 0x08, 0x08, 0x91, the thread byte, word[7:0], word[15:8], word[23:16], word[31:24], word[63:56].
- R6: For kind 1 (machine-check), 8 bytes are written to 0x73 to 0x7A in this order: 0x07, 0x08, 0x86, the thread byte, word[7:0], word[15:8], word[23:16], word[31:24].
- R7: After the message, `STAT_ADDR` is read at once and again until bit 7 is set. Successive status accesses complete POLL_CYC+2 cycles apart with a one-cycle-latency port. If a status read shows the flag clear after TIMEOUT_CYC cycles of polling, the request ends with err_code 2 and no further access.
- R8: When the flag is seen, 10 bytes are read from 0x73 to 0x7C in ascending order. Then 0x80 is written to `STAT_ADDR`.
- R9: If the first response byte is not 9, err_code is 3 (size).
- R10: If the first response byte is 9 and the second is not 0, err_code is 4 and `fw_code` holds the second byte. In every other outcome, `fw_code` is 0.
- R11: If the first response byte is 9 and the second is 0, err_code is 0 and `result` holds response bytes 3 to 10, least significant first.
- R12: On any error, `result` is 0 for a CPUID request. For a machine-check request, `result` is the unchanged request word.
- R13: An access completed with `rp_err` set ends the request at once with err_code 5, and no further access is made.
- R14: `rp_req`, `rp_addr`, `rp_we` and `rp_wdata` stay stable until `rp_ack`. `busy` is high from the accepted request until `done`. `done` pulses for one cycle in which `busy` is low. `req_valid` is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a request (sampled while idle) |
| req_kind | input | 1 | 0 = CPUID, 1 = machine-check register |
| req_word | input | 64 | Request word: thread, index, extended byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Returned data, held until next completion |
| err_code | output | 3 | 0 ok, 1 unsupported, 2 timeout, 3 size, 4 protocol, 5 bus |
| fw_code | output | 8 | Remote status byte on protocol error |
| rp_req | output | 1 | Register access request |
| rp_we | output | 1 | Access is a write |
| rp_addr | output | ADDR_W | Register address |
| rp_wdata | output | 8 | Write data |
| rp_ack | input | 1 | Access completes this cycle |
| rp_rdata | input | 8 | Read data, valid with `rp_ack` |
| rp_err | input | 1 | Access failed, valid with `rp_ack` |

## Verification
The bench builds the sequencer with POLL_CYC=4 and TIMEOUT_CYC=60, in place of the real-time defaults. The exact spacing between status polls can then be predicted and compared cycle for cycle. The timeout path is also reached after about ten unanswered polls. The responder model answers in one cycle, raises the completion flag on a chosen status read, and can fail any chosen access. This puts bus aborts at a precise point in the message within reach.

// File: rtl/sbseq_pkg.sv
package sbseq_pkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_NOSUP   = 3'd1,
    ERR_TIMEOUT = 3'd2,
    ERR_SIZE    = 3'd3,
    ERR_PROTO   = 3'd4,
    ERR_BUS     = 3'd5
  } err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_REV, S_BANK, S_MSG, S_POLL_RD, S_POLL_WAIT, S_RSP, S_CLR
  } st_e;

  typedef struct packed {
    logic       bank;
    logic [7:0] tbyte;
  } thr_t;

  localparam logic       KIND_CPUID = 1'b0;
  localparam logic [7:0] CMD_CPUID  = 8'h91;
  localparam logic [7:0] CMD_MCA    = 8'h86;
  localparam logic [7:0] REV_NOSUP  = 8'h10;
  localparam logic [7:0] CLR_ALERT  = 8'h80;
  localparam int         RSP_LEN    = 10;
  localparam logic [7:0] RSP_COUNT  = 8'd9;

  // Thread index -> bank select plus shifted in-bank byte
  function automatic thr_t split_thread(input logic [15:0] t);
    thr_t r;
    r.bank  = (t > 16'd127);
    r.tbyte = r.bank ? 8'((t - 16'd128) << 1) : 8'(t << 1);
    return r;
  endfunction

  function automatic logic [3:0] msg_len(input logic kind);
    return (kind == KIND_CPUID) ? 4'd9 : 4'd8;
  endfunction

  function automatic logic [7:0] msg_byte(input logic kind, input logic [3:0] idx,
                                          input logic [7:0] tb, input logic [31:0] fn,
                                          input logic [7:0] ext);
    case (idx)
      4'd0:    return (kind == KIND_CPUID) ? 8'h08 : 8'h07;
      4'd1:    return 8'h08;
      4'd2:    return (kind == KIND_CPUID) ? CMD_CPUID : CMD_MCA;
      4'd3:    return tb;
      4'd4:    return fn[7:0];
      4'd5:    return fn[15:8];
      4'd6:    return fn[23:16];
      4'd7:    return fn[31:24];
      4'd8:    return ext;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sbseq_timer.sv
module sbseq_timer #(
  parameter int POLL_CYC    = 100000,
  parameter int TIMEOUT_CYC = 400000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic wait_en,
  output logic tick,
  output logic expired
);
  localparam int IW = (POLL_CYC < 2) ? 1 : $clog2(POLL_CYC + 1);
  localparam int EW = $clog2(TIMEOUT_CYC + 1);

  logic [IW-1:0] ivl_q;
  logic [EW-1:0] el_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
      el_q  <= '0;
    end else begin
      ivl_q <= wait_en ? ivl_q + 1'b1 : '0;
      if (restart)                       el_q <= '0;
      else if (el_q < EW'(TIMEOUT_CYC))  el_q <= el_q + 1'b1;
    end
  end

  assign tick    = wait_en && (ivl_q == IW'(POLL_CYC - 1));
  assign expired = (el_q >= EW'(TIMEOUT_CYC));
endmodule

// File: rtl/sbseq_msg.sv
module sbseq_msg
  import sbseq_pkg::*;
(
  input  logic        kind,
  input  logic [3:0]  idx,
  input  logic [7:0]  tbyte,
  input  logic [31:0] fn,
  input  logic [7:0]  ext,
  output logic [7:0]  mbyte,
  output logic        last
);
  assign mbyte = msg_byte(kind, idx, tbyte, fn, ext);
  assign last  = (idx == msg_len(kind) - 4'd1);
endmodule

// File: rtl/sbseq_rsp.sv
module sbseq_rsp
  import sbseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap,
  input  logic [3:0]  idx,
  input  logic [7:0]  din,
  output logic [7:0]  cnt_byte,
  output logic [7:0]  stat_byte,
  output logic [63:0] value
);
  logic [7:0] buf_q [RSP_LEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RSP_LEN; i++) buf_q[i] <= '0;
    end else if (cap) begin
      buf_q[idx] <= din;
    end
  end

  assign cnt_byte  = buf_q[0];
  assign stat_byte = buf_q[1];

  for (genvar g = 0; g < 8; g++) begin : g_val
    assign value[8*g +: 8] = buf_q[g+2];
  end
endmodule

// File: rtl/sb_cpuid_seq.sv
module sb_cpuid_seq
  import sbseq_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              POLL_CYC    = 100000,
  parameter int              TIMEOUT_CYC = 400000000,
  parameter logic [ADDR_W-1:0] REV_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 8'h4B,
  parameter logic [ADDR_W-1:0] MSG_ADDR  = 8'h73
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_kind,
  input  logic [63:0]       req_word,
  output logic              busy,
  output logic              done,
  output logic [63:0]       result,
  output logic [2:0]        err_code,
  output logic [7:0]        fw_code,
  output logic              rp_req,
  output logic              rp_we,
  output logic [ADDR_W-1:0] rp_addr,
  output logic [7:0]        rp_wdata,
  input  logic              rp_ack,
  input  logic [7:0]        rp_rdata,
  input  logic              rp_err
);
  st_e         state_q, state_d;
  logic [3:0]  idx_q, idx_d;
  logic        kind_q, rev_valid_q, done_q;
  logic [7:0]  rev_q, fw_q;
  logic [63:0] word_q, result_q;
  err_e        err_q;

  // named internal events
  logic        xfer, bus_fault, msg_last, poll_tick, poll_expired, poll_start;
  logic        fin, kind_eff;
  err_e        fin_err;
  logic [7:0]  fin_fw, msg_b, rsp_cnt, rsp_stat;
  logic [63:0] rsp_val, word_eff;
  thr_t        thr;

  assign xfer      = rp_req && rp_ack;
  assign bus_fault = xfer && rp_err;
  assign thr       = split_thread(word_q[47:32]);
  assign poll_start = (state_q == S_MSG) && xfer && msg_last;
  assign kind_eff  = (state_q == S_IDLE) ? req_kind : kind_q;
  assign word_eff  = (state_q == S_IDLE) ? req_word : word_q;

  sbseq_msg u_msg (
    .kind(kind_q), .idx(idx_q), .tbyte(thr.tbyte), .fn(word_q[31:0]),
    .ext(word_q[63:56]), .mbyte(msg_b), .last(msg_last)
  );

  sbseq_timer #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(poll_start),
    .wait_en(state_q == S_POLL_WAIT), .tick(poll_tick), .expired(poll_expired)
  );

  sbseq_rsp u_rsp (
    .clk(clk), .rst_n(rst_n), .cap((state_q == S_RSP) && xfer && !rp_err),
    .idx(idx_q), .din(rp_rdata), .cnt_byte(rsp_cnt), .stat_byte(rsp_stat),
    .value(rsp_val)
  );

  // register port drive
  always_comb begin
    rp_req   = 1'b1;
    rp_we    = 1'b0;
    rp_addr  = STAT_ADDR;
    rp_wdata = 8'h00;
    case (state_q)
      S_REV:     rp_addr = REV_ADDR;
      S_BANK:    begin rp_we = 1'b1; rp_addr = BANK_ADDR; rp_wdata = {7'd0, thr.bank}; end
      S_MSG:     begin rp_we = 1'b1; rp_addr = MSG_ADDR + ADDR_W'(idx_q); rp_wdata = msg_b; end
      S_POLL_RD: rp_addr = STAT_ADDR;
      S_RSP:     rp_addr = MSG_ADDR + ADDR_W'(idx_q);
      S_CLR:     begin rp_we = 1'b1; rp_wdata = CLR_ALERT; end
      default:   rp_req = 1'b0;
    endcase
  end

  // sequencing
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    fin     = 1'b0;
    fin_err = ERR_NONE;
    fin_fw  = 8'h00;
    case (state_q)
      S_IDLE: if (req_valid) begin
        idx_d = '0;
        if (!rev_valid_q)            state_d = S_REV;
        else if (rev_q == REV_NOSUP) begin fin = 1'b1; fin_err = ERR_NOSUP; end
        else                         state_d = S_BANK;
      end
      S_REV: if (xfer) begin
        if (rp_rdata == REV_NOSUP) begin fin = 1'b1; fin_err = ERR_NOSUP; end
        else state_d = S_BANK;
      end
      S_BANK: if (xfer) state_d = S_MSG;
      S_MSG: if (xfer) begin
        if (msg_last) begin state_d = S_POLL_RD; idx_d = '0; end
        else idx_d = idx_q + 4'd1;
      end
      S_POLL_RD: if (xfer) begin
        if (rp_rdata[7])       begin state_d = S_RSP; idx_d = '0; end
        else if (poll_expired) begin fin = 1'b1; fin_err = ERR_TIMEOUT; end
        else                   state_d = S_POLL_WAIT;
      end
      S_POLL_WAIT: if (poll_tick) state_d = S_POLL_RD;
      S_RSP: if (xfer) begin
        if (idx_q == 4'(RSP_LEN - 1)) state_d = S_CLR;
        else idx_d = idx_q + 4'd1;
      end
      S_CLR: if (xfer) begin
        fin = 1'b1;
        if (rsp_cnt != RSP_COUNT)  fin_err = ERR_SIZE;
        else if (rsp_stat != 8'h0) begin fin_err = ERR_PROTO; fin_fw = rsp_stat; end
      end
      default: state_d = S_IDLE;
    endcase
    if (bus_fault) begin fin = 1'b1; fin_err = ERR_BUS; fin_fw = 8'h00; end
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      kind_q      <= 1'b0;
      word_q      <= '0;
      rev_valid_q <= 1'b0;
      rev_q       <= '0;
      done_q      <= 1'b0;
      result_q    <= '0;
      err_q       <= ERR_NONE;
      fw_q        <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= fin;
      if (state_q == S_IDLE && req_valid) begin
        kind_q <= req_kind;
        word_q <= req_word;
      end
      if (state_q == S_REV && xfer && !rp_err) begin
        rev_valid_q <= 1'b1;
        rev_q       <= rp_rdata;
      end
      if (fin) begin
        err_q <= fin_err;
        fw_q  <= fin_fw;
        if (fin_err == ERR_NONE)       result_q <= rsp_val;
        else if (kind_eff == KIND_CPUID) result_q <= '0;
        else                           result_q <= word_eff;
      end
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign done     = done_q;
  assign result   = result_q;
  assign err_code = err_q;
  assign fw_code  = fw_q;
endmodule

// File: rtl/sbseq_chk.sv
module sbseq_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 8'h4B
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [63:0]       result,
  input logic [2:0]        err_code,
  input logic [7:0]        fw_code,
  input logic              rp_req,
  input logic              rp_we,
  input logic [ADDR_W-1:0] rp_addr,
  input logic [7:0]        rp_wdata,
  input logic              rp_ack,
  input logic              rp_err,
  input logic              kind_q,
  input logic              rev_valid_q,
  input logic [7:0]        rev_q
);
  assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req && !rp_ack |=> rp_req && $stable(rp_addr) && $stable(rp_we) && $stable(rp_wdata));

  assert_done_not_busy_R14: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_end_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_nosup_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rev_valid_q && rev_q == 8'h10 |-> !rp_req);

  assert_clear_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req && rp_we && rp_addr == STAT_ADDR |-> rp_wdata == 8'h80);

  assert_bank_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req && rp_we && rp_addr == BANK_ADDR |-> rp_wdata[7:1] == 7'd0);

  assert_cpuid_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done && !kind_q && err_code != 3'd0 && err_code != 3'd1 |-> result == 64'd0);

  assert_fw_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_code != 3'd4 |-> fw_code == 8'd0);

  assert_bus_abort_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req && rp_ack && rp_err |=> !rp_req && done && err_code == 3'd5);
endmodule

bind sb_cpuid_seq sbseq_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .BANK_ADDR(BANK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .err_code(err_code), .fw_code(fw_code), .rp_req(rp_req), .rp_we(rp_we),
  .rp_addr(rp_addr), .rp_wdata(rp_wdata), .rp_ack(rp_ack), .rp_err(rp_err),
  .kind_q(kind_q), .rev_valid_q(rev_valid_q), .rev_q(rev_q)
);

// File: tb/sb_cpuid_seq_tb.sv
module sb_cpuid_seq_tb;
  localparam int         POLLC = 4;
  localparam int         TOC   = 60;
  localparam logic [7:0] REVA  = 8'h00;
  localparam logic [7:0] STATA = 8'h02;
  localparam logic [7:0] BANKA = 8'h4B;
  localparam logic [7:0] MSGA  = 8'h73;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_kind = 1'b0;
  logic [63:0] req_word = '0;
  logic busy, done, rp_req, rp_we, rp_err;
  logic [63:0] result;
  logic [2:0] err_code;
  logic [7:0] fw_code, rp_addr, rp_wdata, rp_rdata;
  logic ack_q;

  always #2.5 clk = ~clk;

  sb_cpuid_seq #(.POLL_CYC(POLLC), .TIMEOUT_CYC(TOC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_word(req_word), .busy(busy), .done(done), .result(result),
    .err_code(err_code), .fw_code(fw_code), .rp_req(rp_req), .rp_we(rp_we),
    .rp_addr(rp_addr), .rp_wdata(rp_wdata), .rp_ack(ack_q), .rp_rdata(rp_rdata),
    .rp_err(rp_err)
  );

  // responder model
  logic [7:0] rev_val = 8'h20;
  logic [7:0] rsp [10];
  int         alert_after = 1;
  int         err_at = -1;
  logic       log_clr = 1'b0;
  int         acc_n, stat_reads, lg_n, cyc;
  logic       cleared;
  logic       lg_we   [64];
  logic [7:0] lg_addr [64];
  logic [7:0] lg_data [64];
  int         lg_t    [64];

  assign rp_err = ack_q && (acc_n == err_at);

  always_comb begin
    rp_rdata = 8'h00;
    if (rp_addr == REVA) rp_rdata = rev_val;
    else if (rp_addr == STATA)
      rp_rdata = {((stat_reads + 1 >= alert_after) && !cleared), 7'd0};
    else if (rp_addr >= MSGA && rp_addr < MSGA + 8'd10) rp_rdata = rsp[rp_addr - MSGA];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= rp_req && !ack_q;
  end

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (log_clr) begin
      lg_n <= 0; acc_n <= 0; stat_reads <= 0; cleared <= 1'b0;
    end else if (rp_req && ack_q) begin
      acc_n <= acc_n + 1;
      if (lg_n < 64) begin
        lg_we[lg_n]   <= rp_we;
        lg_addr[lg_n] <= rp_addr;
        lg_data[lg_n] <= rp_we ? rp_wdata : rp_rdata;
        lg_t[lg_n]    <= cyc;
        lg_n          <= lg_n + 1;
      end
      if (!rp_we && rp_addr == STATA) stat_reads <= stat_reads + 1;
      if (rp_we && rp_addr == STATA && rp_wdata[7]) cleared <= 1'b1;
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [63:0] got_res;
  logic [2:0]  got_err;
  logic [7:0]  got_fw;
  logic        busy_seen;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
  endtask

  task automatic set_rsp(input logic [7:0] cnt, input logic [7:0] st, input logic [63:0] v);
    rsp[0] = cnt; rsp[1] = st;
    for (int i = 0; i < 8; i++) rsp[i+2] = v[8*i +: 8];
  endtask

  // issue one request; optionally pulse a second request while busy
  task automatic issue(input logic kind, input logic [63:0] w,
                       input bit extra, input logic [63:0] w2);
    int n;
    bit seen;
    clear_log();
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_word = w;
    n = 0; seen = 0; busy_seen = 1'b0;
    while (!seen && n < 3000) begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
      if (busy) busy_seen = 1'b1;
      if (extra && n == 5) begin req_valid = 1'b1; req_kind = ~kind; req_word = w2; end
      if (extra && n == 6) req_valid = 1'b0;
      if (done) seen = 1;
    end
    req_valid = 1'b0;
    chk("R14 done pulse reached", seen, 1'b1);
    got_res = result; got_err = err_code; got_fw = fw_code;
    @(negedge clk);
    chk("R14 done is one cycle", done, 1'b0);
  endtask

  function automatic logic [7:0] expb(input logic kind, input int i,
                                      input logic [63:0] w, input logic [7:0] tb);
    case (i)
      0: return kind ? 8'h07 : 8'h08;
      1: return 8'h08;
      2: return kind ? 8'h86 : 8'h91;
      3: return tb;
      8: return w[63:56];
      default: return w[8*(i-4) +: 8];
    endcase
  endfunction

  // full access trace from bank write up to the alert clear
  task automatic verify_flow(input logic kind, input logic [63:0] w, input int n_stat);
    int p, t, len;
    logic eb;
    logic [7:0] tb;
    p = (lg_n > 0 && !lg_we[0] && lg_addr[0] == REVA) ? 1 : 0;
    t = int'(w[47:32]);
    eb = (t > 127);
    tb = eb ? 8'((t - 128) << 1) : 8'(t << 1);
    chk("R4 bank write", {lg_we[p], lg_addr[p], lg_data[p]}, {1'b1, BANKA, 7'd0, eb});
    p++;
    len = kind ? 8 : 9;
    for (int i = 0; i < len; i++) begin
      chk(kind ? "R6 message byte" : "R5 message byte",
          {lg_we[p], lg_addr[p], lg_data[p]}, {1'b1, MSGA + 8'(i), expb(kind, i, w, tb)});
      p++;
    end
    for (int s = 0; s < n_stat; s++) begin
      chk("R7 status poll", {lg_we[p], lg_addr[p]}, {1'b0, STATA});
      if (s > 0) chk("R7 poll spacing", 64'(lg_t[p] - lg_t[p-1]), 64'(POLLC + 2));
      p++;
    end
    for (int i = 0; i < 10; i++) begin
      chk("R8 response read", {lg_we[p], lg_addr[p]}, {1'b0, MSGA + 8'(i)});
      p++;
    end
    chk("R8 alert clear", {lg_we[p], lg_addr[p], lg_data[p]}, {1'b1, STATA, 8'h80});
    p++;
    chk("R8 access count", 64'(lg_n), 64'(p));
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 rp_req", rp_req, 1'b0);
    chk("R1 result", result, 64'd0);
    chk("R1 err", err_code, 3'd0);
    chk("R1 fw", fw_code, 8'd0);
  endtask

  task automatic t_cpuid_low();
    logic [63:0] w = 64'h5A00_0005_8000_0001;
    alert_after = 3;
    set_rsp(8'd9, 8'd0, 64'h1122_3344_5566_7788);
    issue(1'b0, w, 1'b0, 64'd0);
    chk("R2 first request reads revision", {lg_we[0], lg_addr[0]}, {1'b0, REVA});
    verify_flow(1'b0, w, 3);
    chk("R11 result", got_res, 64'h1122_3344_5566_7788);
    chk("R11 err ok", got_err, 3'd0);
    chk("R10 fw zero", got_fw, 8'd0);
    chk("R14 busy seen", busy_seen, 1'b1);
  endtask

  task automatic t_cpuid_high();
    logic [63:0] w = 64'h0000_00C8_0000_0007;
    alert_after = 1;
    set_rsp(8'd9, 8'd0, 64'h0F0E_0D0C_0B0A_0908);
    issue(1'b0, w, 1'b0, 64'd0);
    chk("R2 revision not re-read", {lg_we[0], lg_addr[0]}, {1'b1, BANKA});
    verify_flow(1'b0, w, 1);
    chk("R11 result high thread", got_res, 64'h0F0E_0D0C_0B0A_0908);
  endtask

  task automatic t_mca();
    logic [63:0] w = 64'h0000_0003_0000_0413;
    alert_after = 2;
    set_rsp(8'd9, 8'd0, 64'hCAFE_F00D_DEAD_BEEF);
    issue(1'b1, w, 1'b0, 64'd0);
    verify_flow(1'b1, w, 2);
    chk("R11 mca result", got_res, 64'hCAFE_F00D_DEAD_BEEF);
    chk("R11 mca err", got_err, 3'd0);
  endtask

  task automatic t_size();
    logic [63:0] w = 64'h0000_0010_0000_0002;
    alert_after = 1;
    set_rsp(8'd8, 8'd0, 64'h1234);
    issue(1'b0, w, 1'b0, 64'd0);
    verify_flow(1'b0, w, 1);
    chk("R9 size err", got_err, 3'd3);
    chk("R12 cpuid result zero", got_res, 64'd0);
  endtask

  task automatic t_proto();
    logic [63:0] w = 64'h0000_0081_0000_00A5;
    alert_after = 1;
    set_rsp(8'd9, 8'h5A, 64'h55);
    issue(1'b1, w, 1'b0, 64'd0);
    verify_flow(1'b1, w, 1);
    chk("R10 proto err", got_err, 3'd4);
    chk("R10 fw code", got_fw, 8'h5A);
    chk("R12 mca result is input", got_res, w);
  endtask

  task automatic t_timeout();
    int rsp_reads;
    alert_after = 100000;
    issue(1'b0, 64'h0000_0001_0000_0001, 1'b0, 64'd0);
    chk("R7 timeout err", got_err, 3'd2);
    chk("R12 timeout result zero", got_res, 64'd0);
    chk("R7 last access is status read", {lg_we[lg_n-1], lg_addr[lg_n-1]}, {1'b0, STATA});
    rsp_reads = 0;
    for (int i = 0; i < lg_n; i++) if (!lg_we[i] && lg_addr[i] == MSGA) rsp_reads++;
    chk("R7 no response read after timeout", 64'(rsp_reads), 64'd0);
    chk("R7 polled several times", 64'(lg_n > 12), 64'd1);
  endtask

  task automatic t_buserr();
    alert_after = 1;
    err_at = 1;
    issue(1'b0, 64'h0000_0002_0000_0003, 1'b0, 64'd0);
    err_at = -1;
    chk("R13 bus err code", got_err, 3'd5);
    chk("R13 abort access count", 64'(lg_n), 64'd2);
    chk("R13 cpuid result zero", got_res, 64'd0);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] w = 64'h0000_0007_0000_0099;
    alert_after = 2;
    set_rsp(8'd9, 8'd0, 64'hA5A5_0000_1111_2222);
    issue(1'b1, w, 1'b1, 64'h0000_00FF_FFFF_FFFF);
    verify_flow(1'b1, w, 2);
    chk("R14 request while busy ignored", got_res, 64'hA5A5_0000_1111_2222);
    repeat (4) @(negedge clk);
    chk("R14 no second transfer", busy, 1'b0);
  endtask

  task automatic t_unsup();
    @(negedge clk) rst_n = 1'b0;
    rev_val = 8'h10;
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    issue(1'b0, 64'h0000_0001_0000_0001, 1'b0, 64'd0);
    chk("R3 unsupported err", got_err, 3'd1);
    chk("R3 only revision read", 64'(lg_n), 64'd1);
    chk("R3 cpuid result zero", got_res, 64'd0);
    issue(1'b1, 64'h0000_0004_0000_0044, 1'b0, 64'd0);
    chk("R3 cached reject err", got_err, 3'd1);
    chk("R3 no access on cached reject", 64'(lg_n), 64'd0);
    chk("R12 mca reject returns input", got_res, 64'h0000_0004_0000_0044);
  endtask

  initial begin
    cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cpuid_low();
    t_cpuid_high();
    t_mca();
    t_size();
    t_proto();
    t_timeout();
    t_buserr();
    t_busy_ignore();
    t_unsup();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule